// File: doc/BRIEF.md
# Multiplexed Pixel Input Demultiplexer

This block receives pixels over a 12-bit bus that carries every pixel as two sub-words, first "a" and then "b". It rebuilds one 24-bit pixel with its horizontal sync, vertical sync and data-enable qualifiers. A source that runs at the pixel rate uses both clock edges, one sub-word per edge. A source that runs at twice the pixel rate uses one clock edge per sub-word, and a control bit chooses that edge. A format code decides how the 24 sub-word bits land in the output word. Three packings are full or reduced RGB. One packing carries interleaved 8-bit luma and chroma samples.

In the luma/chroma packing the block follows which chroma component the current pixel carries. It also picks out start-of-active-video codes in the stream. Each code takes the form of an all-zero pixel followed by a status pixel. The block keeps three bits of the status byte and puts the chroma phase back to Cb. The output is registered and carries a one-cycle valid strobe per completed pair.

Top module: `pix_demux`

## Requirements
- R1: While rst_n is low, and on the first rising edge after it, pix_valid, pix_data, pix_cr and sav_status are all zero.
- R2: With ddr_mode=1 and clk_invert=0, sub-word a is the bus value sampled on a falling edge and b is the value sampled on the next rising edge. With clk_invert=1, a is sampled on a rising edge and b on the next falling edge. Each pair gives exactly one output pixel.
- R3: With ddr_mode=0, one sub-word is taken per clock cycle, on the rising edge when clk_invert=0 and on the falling edge when clk_invert=1. pix_valid never stays high for two cycles in a row.
- R4: With ddr_mode=0, a sub-word whose de_in is 1 while the previous sub-word had de_in 0 is always taken as sub-word a, whatever the pairing phase was.
- R5: Format 0: pix_data[23:12]=b[11:0] and pix_data[11:0]=a[11:0].
- R6: Format 1: pix_data[23:16]={b[11:7],b[3:1]}, pix_data[15:8]={b[6:4],a[11:9],b[0],a[3]} and pix_data[7:0]={a[8:4],a[2:0]}.
- R7: Format 2 (5-6-5): red {b[11:7],000}, green {b[6:4],a[11:9],00}, blue {a[8:4],000}. The low four bits of both sub-words have no effect.
- R8: Format 3 (5-5-5): red {b[10:6],000}, green {b[5:4],a[11:9],000}, blue {a[8:4],000}. Bit b[11] and the low four bits of both sub-words have no effect.
- R9: Format 4: the samples sit on bus bits [7:0]. pix_data[23:16]=b[7:0] (luma), pix_data[15:8]=a[7:0] (chroma) and pix_data[7:0]=0.
- R10: Format 4: pix_cr is 0 (Cb) for the first active pixel after reset and toggles after every pixel emitted with de=1. In other formats pix_cr is 0.
- R11: Format 4: a pair with a[7:0]=0 and b[7:0]=0 is emitted normally. The pair after it is a status pair and gives no pix_valid. sav_status takes a[6:4] of that pair, a[7] and a[3:0] have no effect on it, and the next active pixel has pix_cr=0.
- R12: Format codes 5 to 7 give pix_data=0 on every valid pixel.
- R13: pix_hsync, pix_vsync and pix_de are the qualifiers that came with sub-word a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input-bus clock (pixel rate or twice pixel rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| ddr_mode | input | 1 | 1: capture on both edges; 0: one edge per sub-word |
| clk_invert | input | 1 | Chooses which edge captures first (see R2, R3) |
| fmt | input | 3 | Sub-word packing code 0..4 |
| din | input | 12 | Multiplexed data bus |
| hsync_in | input | 1 | Horizontal sync qualifier |
| vsync_in | input | 1 | Vertical sync qualifier |
| de_in | input | 1 | Data-enable qualifier |
| pix_valid | output | 1 | One-cycle strobe per rebuilt pixel |
| pix_data | output | 24 | Rebuilt pixel |
| pix_hsync | output | 1 | Horizontal sync of the pixel |
| pix_vsync | output | 1 | Vertical sync of the pixel |
| pix_de | output | 1 | Data enable of the pixel |
| pix_cr | output | 1 | Chroma phase in format 4: 0 Cb, 1 Cr |
| sav_status | output | 3 | Kept bits of the last status byte |

## Verification
Each format is driven in a different clocking mode, so both edge choices are covered in single-edge and dual-edge capture. Each packing's expected word is built in the bench from colour fields and not from bus bits. Noise goes in the unused nibbles, so a mapping that leaks them shows up. The sync qualifiers differ between a and b, so a block that takes them from the wrong sub-word is told apart. In single-edge runs an odd run of blanking words comes before the active burst, so only a block that resyncs on the data-enable edge pairs the burst correctly. The luma/chroma run puts two start codes with noisy status bytes between active pixels, which tests the chroma reset, the suppressed status pixel and the kept status bits.

// File: rtl/pix_demux_pkg.sv
// Package: shared widths, format codes and the sub-word record.
// Assumes: bus and pixel widths are fixed by the packings (12 in, 24 out).
package pix_demux_pkg;

    localparam int SUB_W   = 12;
    localparam int PIX_W   = 24;
    localparam int FMT_W   = 3;
    localparam int SAMP_W  = 8;
    localparam int STAT_W  = 3;
    localparam int STAT_LO = 4;

    typedef enum logic [FMT_W-1:0] {
        FMT_WIDE12  = 3'd0,
        FMT_MIX888  = 3'd1,
        FMT_RGB565  = 3'd2,
        FMT_RGB555  = 3'd3,
        FMT_YC422   = 3'd4
    } fmt_e;

    typedef struct packed {
        logic [SUB_W-1:0] d;
        logic             hs;
        logic             vs;
        logic             de;
    } subword_t;

endpackage

// File: rtl/pix_demux_capture.sv
// Edge capture: samples the bus on both clock edges and presents, on each
// rising edge, the a/b candidates for the selected clocking mode.
// Assumes: ddr_mode and clk_invert are static while out of reset.
module pix_demux_capture
    import pix_demux_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clk_invert,
    input  subword_t bus_now,
    output subword_t sub_a,
    output subword_t sub_b
);

    subword_t fall_q;
    subword_t rise_q;

    // Hold the bus value seen at each falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= bus_now;
    end

    // Hold the bus value seen at the previous rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= bus_now;
    end

    // Later sample is the current edge's sub-word; earlier one precedes it.
    always_comb begin
        sub_b = clk_invert ? fall_q : bus_now;
        sub_a = clk_invert ? rise_q : fall_q;
    end

endmodule

// File: rtl/pix_demux_pair.sv
// Pair assembler: forms a/b pairs. Dual-edge mode yields one pair every
// cycle; single-edge mode alternates and resyncs on a data-enable rise.
// Assumes: sub_b is the single sub-word of the cycle in single-edge mode.
module pix_demux_pair
    import pix_demux_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ddr_mode,
    input  subword_t sub_a,
    input  subword_t sub_b,
    output subword_t pair_a,
    output subword_t pair_b,
    output logic     pair_v
);

    subword_t hold_q;
    logic     want_b;
    logic     de_last;
    logic     de_rise;

    // A sub-word with enable high after one with it low opens a pixel.
    always_comb de_rise = sub_b.de && !de_last;

    // Sequence sub-words into pairs and strobe each completed one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            want_b  <= 1'b0;
            de_last <= 1'b0;
            pair_a  <= '0;
            pair_b  <= '0;
            pair_v  <= 1'b0;
        end else begin
            de_last <= sub_b.de;
            if (ddr_mode) begin
                pair_a <= sub_a;
                pair_b <= sub_b;
                pair_v <= 1'b1;
                want_b <= 1'b0;
            end else if (de_rise || !want_b) begin
                hold_q <= sub_b;
                want_b <= 1'b1;
                pair_v <= 1'b0;
            end else begin
                pair_a <= hold_q;
                pair_b <= sub_b;
                pair_v <= 1'b1;
                want_b <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pix_demux_unpack.sv
// Unpacker: maps a pair to a 24-bit pixel by format code, tracks chroma
// phase and start-of-active-video codes in the luma/chroma packing, and
// registers the result.
// Assumes: fmt is static while out of reset; zero bytes are reserved for codes.
module pix_demux_unpack
    import pix_demux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FMT_W-1:0]  fmt,
    input  subword_t          pair_a,
    input  subword_t          pair_b,
    input  logic              pair_v,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_data,
    output logic              pix_hsync,
    output logic              pix_vsync,
    output logic              pix_de,
    output logic              pix_cr,
    output logic [STAT_W-1:0] sav_status
);

    localparam int HALF = SAMP_W / 2;

    logic [SUB_W-1:0]  a;
    logic [SUB_W-1:0]  b;
    logic [PIX_W-1:0]  mapped;
    logic              is_yc;
    logic              zero_seen;
    logic              cr_phase;
    logic              is_status;
    logic              pair_zero;

    // Short names for the two sub-word data fields.
    always_comb begin
        a = pair_a.d;
        b = pair_b.d;
    end

    // Select the bit placement for the configured packing.
    always_comb begin
        case (fmt)
            FMT_WIDE12: mapped = {b, a};
            FMT_MIX888: mapped = {b[11:7], b[3:1],
                                  b[6:4], a[11:9], b[0], a[3],
                                  a[8:4], a[2:0]};
            FMT_RGB565: mapped = {b[11:7], 3'b000,
                                  b[6:4], a[11:9], 2'b00,
                                  a[8:4], 3'b000};
            FMT_RGB555: mapped = {b[10:6], 3'b000,
                                  b[5:4], a[11:9], 3'b000,
                                  a[8:4], 3'b000};
            FMT_YC422:  mapped = {b[SAMP_W-1:0], a[SAMP_W-1:0], {SAMP_W{1'b0}}};
            default:    mapped = '0;
        endcase
    end

    // Flag the code pairs of the luma/chroma stream.
    always_comb begin
        is_yc     = (fmt == FMT_YC422);
        pair_zero = (a[SAMP_W-1:0] == '0) && (b[SAMP_W-1:0] == '0);
        is_status = is_yc && zero_seen;
    end

    // Register the pixel, the chroma phase and the start-code status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid  <= 1'b0;
            pix_data   <= '0;
            pix_hsync  <= 1'b0;
            pix_vsync  <= 1'b0;
            pix_de     <= 1'b0;
            pix_cr     <= 1'b0;
            sav_status <= '0;
            zero_seen  <= 1'b0;
            cr_phase   <= 1'b0;
        end else begin
            pix_valid <= pair_v && !is_status;
            if (pair_v) begin
                if (is_status) begin
                    sav_status <= a[STAT_LO +: STAT_W];
                    cr_phase   <= 1'b0;
                    zero_seen  <= 1'b0;
                end else begin
                    pix_data  <= mapped;
                    pix_hsync <= pair_a.hs;
                    pix_vsync <= pair_a.vs;
                    pix_de    <= pair_a.de;
                    pix_cr    <= is_yc && cr_phase;
                    zero_seen <= is_yc && pair_zero;
                    if (!is_yc)          cr_phase <= 1'b0;
                    else if (pair_a.de)  cr_phase <= !cr_phase;
                end
            end
        end
    end

    // HALF documents the nibble size left unused by 8-bit samples.
    initial if (HALF != 4) $display("pix_demux_unpack: unexpected sample width");

endmodule

// File: rtl/pix_demux.sv
// Top: multiplexed pixel input demultiplexer. Wires capture, pairing and
// unpacking; the output is two rising edges behind the last sub-word.
// Assumes: configuration inputs change only while rst_n is low.
module pix_demux
    import pix_demux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ddr_mode,
    input  logic              clk_invert,
    input  logic [2:0]        fmt,
    input  logic [11:0]       din,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              de_in,
    output logic              pix_valid,
    output logic [23:0]       pix_data,
    output logic              pix_hsync,
    output logic              pix_vsync,
    output logic              pix_de,
    output logic              pix_cr,
    output logic [2:0]        sav_status
);

    subword_t bus_now;
    subword_t sub_a;
    subword_t sub_b;
    subword_t pair_a;
    subword_t pair_b;
    logic     pair_v;

    // Bundle the bus with its qualifiers.
    always_comb bus_now = '{d: din, hs: hsync_in, vs: vsync_in, de: de_in};

    pix_demux_capture u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_invert (clk_invert),
        .bus_now    (bus_now),
        .sub_a      (sub_a),
        .sub_b      (sub_b)
    );

    pix_demux_pair u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .ddr_mode (ddr_mode),
        .sub_a    (sub_a),
        .sub_b    (sub_b),
        .pair_a   (pair_a),
        .pair_b   (pair_b),
        .pair_v   (pair_v)
    );

    pix_demux_unpack u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt        (fmt),
        .pair_a     (pair_a),
        .pair_b     (pair_b),
        .pair_v     (pair_v),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .pix_hsync  (pix_hsync),
        .pix_vsync  (pix_vsync),
        .pix_de     (pix_de),
        .pix_cr     (pix_cr),
        .sav_status (sav_status)
    );

endmodule

// File: rtl/pix_demux_chk.sv
// Checker: temporal properties of the demultiplexer outputs, bound to the top.
// Assumes: fmt and ddr_mode are static while out of reset.
module pix_demux_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ddr_mode,
    input logic [2:0]  fmt,
    input logic        pix_valid,
    input logic [23:0] pix_data,
    input logic [2:0]  sav_status
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!pix_valid && sav_status == 3'd0));

    // R3
    sdr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ddr_mode && pix_valid) |=> !pix_valid);

    // R7
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && (fmt == 3'd2 || fmt == 3'd3)) |->
        (pix_data[18:16] == 3'd0 && pix_data[9:8] == 2'd0 && pix_data[2:0] == 3'd0));

    // R9
    yc_lowbyte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && fmt == 3'd4) |-> (pix_data[7:0] == 8'd0));

    // R11
    sav_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sav_status) |-> !pix_valid);

    // R12
    bad_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && fmt > 3'd4) |-> (pix_data == 24'd0));

endmodule

bind pix_demux pix_demux_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ddr_mode   (ddr_mode),
    .fmt        (fmt),
    .pix_valid  (pix_valid),
    .pix_data   (pix_data),
    .sav_status (sav_status)
);

// File: tb/pix_demux_tb.sv
module pix_demux_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ddr_mode = 1'b0;
    logic        clk_invert = 1'b0;
    logic [2:0]  fmt = 3'd0;
    logic [11:0] din = 12'd0;
    logic        hsync_in = 1'b0;
    logic        vsync_in = 1'b0;
    logic        de_in = 1'b0;
    logic        pix_valid;
    logic [23:0] pix_data;
    logic        pix_hsync;
    logic        pix_vsync;
    logic        pix_de;
    logic        pix_cr;
    logic [2:0]  sav_status;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string cur_req = "R1";
    logic [26:0] exp_q[$];   // {cr, hs, vs, data}
    bit    model_cr = 1'b0;

    always #5 clk = ~clk;

    pix_demux u_dut (
        .clk(clk), .rst_n(rst_n), .ddr_mode(ddr_mode), .clk_invert(clk_invert),
        .fmt(fmt), .din(din), .hsync_in(hsync_in), .vsync_in(vsync_in), .de_in(de_in),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_hsync(pix_hsync),
        .pix_vsync(pix_vsync), .pix_de(pix_de), .pix_cr(pix_cr), .sav_status(sav_status)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Compare every active output pixel with the reference queue.
    always @(negedge clk) begin
        if (rst_n && pix_valid && pix_de) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, {5'd0, pix_cr, pix_hsync, pix_vsync, pix_data}, 32'hFFFFFFFF);
            end else begin
                logic [26:0] e;
                e = exp_q.pop_front();
                check({pix_cr, pix_hsync, pix_vsync, pix_data} == e, cur_req,
                      {5'd0, pix_cr, pix_hsync, pix_vsync, pix_data}, {5'd0, e});
            end
        end
    end

    task automatic drive(input logic [11:0] d, input logic h, input logic v, input logic de);
        din = d; hsync_in = h; vsync_in = v; de_in = de;
    endtask

    // One a/b pair in the configured clocking mode.
    task automatic send_pair(input logic [11:0] a, input logic [11:0] b,
                             input logic de, input logic ha, input logic va);
        if (!ddr_mode) begin
            @(posedge clk); #1 drive(a, ha, va, de);
            @(posedge clk); #1 drive(b, !ha, !va, de);
        end else if (!clk_invert) begin
            @(posedge clk); #1 drive(a, ha, va, de);
            @(negedge clk); #1 drive(b, !ha, !va, de);
        end else begin
            @(negedge clk); #1 drive(a, ha, va, de);
            @(posedge clk); #1 drive(b, !ha, !va, de);
        end
    endtask

    task automatic fill_words(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 drive(12'hA5C, 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic fill_pairs(input int n);
        for (int i = 0; i < n; i++) send_pair(12'hA5C, 12'h3B7, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic restart(input bit ddr, input bit inv, input logic [2:0] f, input string req);
        @(posedge clk); #1 rst_n = 1'b0;
        drive(12'hA5C, 1'b0, 1'b0, 1'b0);
        ddr_mode = ddr; clk_invert = inv; fmt = f;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        model_cr = 1'b0;
        cur_req = req;
    endtask

    task automatic drain(input string req);
        if (ddr_mode) fill_pairs(4); else fill_words(8);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // Expected entry helper.
    function automatic logic [26:0] ent(input logic cr, input logic h, input logic v, input logic [23:0] d);
        return {cr, h, v, d};
    endfunction

    // Format 1: scatter a 24-bit pixel into the two sub-words.
    task automatic send_mix(input logic [23:0] p, input logic h);
        logic [11:0] a, b;
        b = {p[23:19], p[15:13], p[18:16], p[9]};
        a = {p[12:10], p[7:3], p[8], p[2:0]};
        exp_q.push_back(ent(1'b0, h, !h, p));
        send_pair(a, b, 1'b1, h, !h);
    endtask

    task automatic send_565(input logic [7:0] r, input logic [7:0] g, input logic [7:0] bl, input logic [3:0] nz);
        exp_q.push_back(ent(1'b0, 1'b1, 1'b0, {r[7:3], 3'd0, g[7:2], 2'd0, bl[7:3], 3'd0}));
        send_pair({g[4:2], bl[7:3], nz}, {r[7:3], g[7:5], ~nz}, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic send_555(input logic [7:0] r, input logic [7:0] g, input logic [7:0] bl, input logic [3:0] nz);
        exp_q.push_back(ent(1'b0, 1'b0, 1'b1, {r[7:3], 3'd0, g[7:3], 3'd0, bl[7:3], 3'd0}));
        send_pair({g[5:3], bl[7:3], nz}, {nz[0], r[7:3], g[7:6], ~nz}, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic send_yc(input logic [7:0] c, input logic [7:0] y);
        exp_q.push_back(ent(model_cr, 1'b1, 1'b1, {y, c, 8'd0}));
        model_cr = !model_cr;
        send_pair({4'h9, c}, {4'h6, y}, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic send_sav(input logic [7:0] stat);
        exp_q.push_back(ent(model_cr, 1'b1, 1'b1, 24'd0));
        send_pair(12'hF00, 12'h700, 1'b1, 1'b1, 1'b1);
        send_pair({4'hC, stat}, 12'h5A5, 1'b1, 1'b1, 1'b1);
        model_cr = 1'b0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pix_valid == 0 && pix_data == 0 && pix_cr == 0 && sav_status == 0,
              "R1", {pix_valid, pix_cr, sav_status, pix_data}, 0);

        // R3 R4 R5 R13: single edge, rising capture, format 0, odd blanking lead
        restart(1'b0, 1'b0, 3'd0, "R3 R4 R5 R13");
        fill_words(3);
        for (int i = 0; i < 4; i++) begin
            logic [11:0] a, b;
            a = 12'h123 + 12'(i * 311);
            b = 12'hF0E - 12'(i * 97);
            exp_q.push_back(ent(1'b0, i[0], !i[0], {b, a}));
            send_pair(a, b, 1'b1, i[0], !i[0]);
        end
        drain("R3 R4 R5");

        // R3 R4 R6 R13: single edge, falling capture, format 1
        restart(1'b0, 1'b1, 3'd1, "R3 R4 R6 R13");
        fill_words(5);
        send_mix(24'hC3A55A, 1'b1);
        send_mix(24'h0F1E2D, 1'b0);
        send_mix(24'hFFFFFF, 1'b1);
        send_mix(24'h800001, 1'b0);
        drain("R4 R6");

        // R2 R7: dual edge, falling then rising, 5-6-5
        restart(1'b1, 1'b0, 3'd2, "R2 R7 R13");
        fill_pairs(2);
        send_565(8'hFF, 8'hFF, 8'hFF, 4'hF);
        send_565(8'hA7, 8'h5B, 8'h3C, 4'h6);
        send_565(8'h07, 8'h03, 8'h07, 4'hF);
        drain("R2 R7");

        // R2 R8: dual edge, rising then falling, 5-5-5
        restart(1'b1, 1'b1, 3'd3, "R2 R8 R13");
        fill_pairs(2);
        send_555(8'hF8, 8'h00, 8'hF8, 4'hF);
        send_555(8'h48, 8'hD8, 8'h90, 4'h9);
        send_555(8'h00, 8'hF8, 8'h00, 4'h3);
        drain("R2 R8");

        // R9 R10 R11: luma/chroma with start codes
        restart(1'b1, 1'b0, 3'd4, "R9 R10 R11");
        fill_pairs(2);
        send_yc(8'h80, 8'h10);
        send_yc(8'h81, 8'h20);
        send_yc(8'h82, 8'h30);
        send_sav(8'hDA);   // kept bits 101
        fill_pairs(2);
        @(negedge clk);
        check(sav_status == 3'b101, "R11", sav_status, 3'b101);
        send_yc(8'h40, 8'hEB);
        send_yc(8'h41, 8'hEA);
        send_yc(8'h42, 8'hE9);
        send_sav(8'hAF);   // kept bits 010
        send_yc(8'h55, 8'h66);
        fill_pairs(2);
        @(negedge clk);
        check(sav_status == 3'b010, "R11", sav_status, 3'b010);
        drain("R9 R10 R11");

        // R12: unused format code
        restart(1'b1, 1'b0, 3'd6, "R12");
        fill_pairs(1);
        exp_q.push_back(ent(1'b0, 1'b1, 1'b0, 24'd0));
        send_pair(12'hFFF, 12'hABC, 1'b1, 1'b1, 1'b0);
        exp_q.push_back(ent(1'b0, 1'b0, 1'b1, 24'd0));
        send_pair(12'h123, 12'h456, 1'b1, 1'b0, 1'b1);
        drain("R12");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule